// File: doc/BRIEF.md
# Sigma-Delta Converter Digital Backend

This block is the logic half of a first-order oversampling sigma-delta analog-to-digital converter whose only analog parts are a comparator and a resistor-capacitor integrator outside the chip. For each channel, one register samples the comparator decision on every modulator clock. The registered level is driven straight back out to the integrator network and acts as the 1-bit feedback DAC. Because the loop is negative feedback, the fraction of ones in that bitstream follows the input amplitude.

Inside the block, the same bitstream feeds a boxcar low-pass filter whose window is R = 2^DEC_LOG2 modulator clocks long. The filter output is sampled once per window, which gives a word of DEC_LOG2+1 bits at 1/R of the modulator rate. An optional DC-blocking stage can follow. A calibration stage then subtracts a programmable offset, scales the result by a programmable unsigned fixed-point gain, and clips it to a signed output word. All channels are identical and run in lockstep from one shared decimation counter, so a single strobe marks valid words on every channel together.

Top module: `sdadc_backend`

## Requirements
- R1: On each rising clock edge outside reset, each channel's feedback register takes the value of its comparator input, and `fb_out[c]` carries that registered level. Reset drives every `fb_out` bit to 0.
- R2: A synchronous reset clears the feedback registers, the boxcar history and sum, the decimation counter, the DC tracker and the output strobe. Number the rising edges after reset release from 0. The first strobe is high in the cycle that follows edge R. Its window covers the levels held on `fb_out` before edges 0 to R-1, so the first of those levels is the cleared 0.
- R3: Each raw word is the number of ones that `fb_out[c]` held over the R clocks of one non-overlapping window. It is an unsigned value from 0 to R and is DEC_LOG2+1 bits wide.
- R4: After the first strobe, `smp_valid` is high for exactly one cycle out of every R and is low in all other cycles.
- R5: The output value is floor(((y - offset) * gain) / 2^GAIN_FRAC). Here `offset_cfg` is a two's complement number of DEC_LOG2+2 bits, `gain_cfg` is unsigned with GAIN_FRAC fractional bits, and y is the filtered word.
- R6: Results above 2^(OUT_W-1)-1 are clipped to that value, and results below -2^(OUT_W-1) are clipped to that value. They never wrap.
- R7: With `hp_en` low, y equals the raw word and the DC tracker is held at zero.
- R8: With `hp_en` high, and with a tracker A that starts at 0 and changes once per decimated word x: y = x - floor(A/2^HP_SHIFT), then A becomes A + x - floor(A/2^HP_SHIFT).
- R9: Channels are independent. Channel c uses `cmp_in[c]` and `fb_out[c]`, and its output occupies `smp_data[c*OUT_W +: OUT_W]`.
- R10: When the loop is closed through an integrator that adds the input and subtracts a full-scale step while feedback is 1, each settled raw word stays within 2 of R times the input-to-full-scale ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | NUM_CH | Comparator decision per channel |
| hp_en | input | 1 | Enables the DC-blocking stage |
| offset_cfg | input | DEC_LOG2+2 | Signed offset subtracted before scaling |
| gain_cfg | input | GAIN_W | Unsigned gain with GAIN_FRAC fractional bits |
| fb_out | output | NUM_CH | Registered 1-bit feedback level per channel |
| smp_valid | output | 1 | One-cycle strobe for a new word on all channels |
| smp_data | output | NUM_CH*OUT_W | Calibrated signed words, channel 0 in the low bits |

## Verification
The bench builds the block with three channels, an 8-clock window, a 2-bit tracker shift, an 8-bit output and a 12-bit gain with 8 fractional bits. With these values the short offset range and the largest gain are enough to drive the output past both clip limits. The small window also lets many decimated words, and the decay of the DC tracker after a step, fit into a short run. One channel held at all ones, one held at all zeros, and a third carrying a mixed pattern show that the channels stay separate. A closed-loop integrator model placed around the feedback pin checks that the density of ones tracks the input at three different input levels.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

    typedef enum logic {
        HP_OFF = 1'b0,
        HP_ON  = 1'b1
    } hp_mode_e;

    localparam int MAX_CHANNELS = 8;

endpackage

// File: rtl/sd_decim_ctl.sv
module sd_decim_ctl #(
    parameter int DEC_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    output logic win_end,
    output logic word_vld,
    output logic out_vld
);
    typedef struct packed {
        logic [DEC_LOG2-1:0] cnt;
        logic                word_vld;
        logic                out_vld;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.cnt      = st_q.cnt + 1'b1;
        st_d.word_vld = (st_q.cnt == {DEC_LOG2{1'b1}});
        st_d.out_vld  = st_q.word_vld;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign win_end  = (st_q.cnt == {DEC_LOG2{1'b1}});
    assign word_vld = st_q.word_vld;
    assign out_vld  = st_q.out_vld;

    // a strobe never lasts two cycles
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.out_vld |=> !st_q.out_vld);

endmodule

// File: rtl/sd_boxcar.sv
module sd_boxcar #(
    parameter int DEC_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmp_bit,
    input  logic                win_end,
    output logic                fb_bit,
    output logic [DEC_LOG2:0]   word
);
    localparam int R     = 1 << DEC_LOG2;
    localparam int SUM_W = DEC_LOG2 + 1;

    typedef struct packed {
        logic             fb;
        logic [R-1:0]     hist;
        logic [SUM_W-1:0] sum;
        logic [SUM_W-1:0] word;
    } box_t;

    box_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fb   = cmp_bit;
        st_d.hist = {st_q.hist[R-2:0], st_q.fb};
        st_d.sum  = st_q.sum + {{(SUM_W-1){1'b0}}, st_q.fb}
                             - {{(SUM_W-1){1'b0}}, st_q.hist[R-1]};
        if (win_end) begin
            st_d.word = st_d.sum;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fb_bit = st_q.fb;
    assign word   = st_q.word;

    assert_fb_follows_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (st_q.fb == $past(cmp_bit)));

    assert_sum_bound_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.sum <= SUM_W'(R));

    assert_sum_matches_R3: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.sum) == $countones(st_q.hist));

endmodule

// File: rtl/sd_dcblock.sv
module sd_dcblock #(
    parameter int DEC_LOG2   = 4,
    parameter bit HP_PRESENT = 1'b1,
    parameter int HP_SHIFT   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hp_en,
    input  logic [DEC_LOG2:0]         x,
    input  logic                      x_vld,
    output logic signed [DEC_LOG2+1:0] y
);
    import sdadc_pkg::*;

    localparam int SUM_W = DEC_LOG2 + 1;
    localparam int YW    = SUM_W + 1;
    localparam int AW    = SUM_W + HP_SHIFT + 2;
    localparam int RMAX  = 1 << DEC_LOG2;

    generate
        if (HP_PRESENT) begin : g_hp
            typedef struct packed {
                logic signed [AW-1:0] acc;
            } dc_t;

            dc_t              st_d, st_q;
            hp_mode_e         mode;
            logic signed [AW-1:0] x_ext;
            logic signed [AW-1:0] tap;
            logic signed [AW-1:0] diff;

            always_comb begin
                mode  = hp_en ? HP_ON : HP_OFF;
                x_ext = $signed({{(AW-SUM_W){1'b0}}, x});
                tap   = st_q.acc >>> HP_SHIFT;
                diff  = x_ext - tap;
                st_d  = st_q;
                if (mode == HP_ON) begin
                    y = $signed(diff[YW-1:0]);
                    if (x_vld) begin
                        st_d.acc = st_q.acc + diff;
                    end
                end else begin
                    y        = $signed({1'b0, x});
                    st_d.acc = '0;
                end
                if (rst) begin
                    st_d = '0;
                end
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            assert_tracker_nonneg_R8: assert property (@(posedge clk) disable iff (rst)
                st_q.acc >= 0);
        end else begin : g_bypass
            assign y = $signed({1'b0, x});
        end
    endgenerate

    assert_y_range_R8: assert property (@(posedge clk) disable iff (rst)
        x_vld |-> (int'(y) >= -RMAX && int'(y) <= RMAX));

    assert_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        (x_vld && !hp_en) |-> (int'(y) == int'(x)));

endmodule

// File: rtl/sd_calib.sv
module sd_calib #(
    parameter int YW        = 6,
    parameter int OFF_W     = 6,
    parameter int GAIN_W    = 12,
    parameter int GAIN_FRAC = 8,
    parameter int OUT_W     = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [YW-1:0]    y,
    input  logic                    y_vld,
    input  logic signed [OFF_W-1:0] offset,
    input  logic [GAIN_W-1:0]       gain,
    output logic [OUT_W-1:0]        q
);
    localparam int DW = ((YW > OFF_W) ? YW : OFF_W) + 1;
    localparam int PW = DW + GAIN_W + 1;
    localparam logic signed [PW-1:0] MAXV = {{(PW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic [GAIN_W-1:0]    UNITY = GAIN_W'(1) << GAIN_FRAC;

    typedef struct packed {
        logic [OUT_W-1:0] q;
    } cal_t;

    cal_t                 st_d, st_q;
    logic signed [DW-1:0] diff;
    logic signed [GAIN_W:0] gain_s;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic [OUT_W-1:0]     clipped;

    always_comb begin
        diff   = y - offset;
        gain_s = $signed({1'b0, gain});
        prod   = diff * gain_s;
        scaled = prod >>> GAIN_FRAC;
        if (scaled > MAXV) begin
            clipped = MAXV[OUT_W-1:0];
        end else if (scaled < MINV) begin
            clipped = MINV[OUT_W-1:0];
        end else begin
            clipped = scaled[OUT_W-1:0];
        end
        st_d = st_q;
        if (y_vld) begin
            st_d.q = clipped;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.q;

    assert_unity_R5: assert property (@(posedge clk) disable iff (rst)
        (y_vld && offset == '0 && gain == UNITY) |=> (int'($signed(st_q.q)) == int'($past(y))));

    // clipping keeps the sign of the corrected value
    assert_sign_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (y_vld && (int'(y) - int'(offset)) > 0) |=> !st_q.q[OUT_W-1]);

endmodule

// File: rtl/sdadc_backend.sv
module sdadc_backend #(
    parameter int NUM_CH     = 8,
    parameter int DEC_LOG2   = 4,
    parameter int OUT_W      = 12,
    parameter int GAIN_W     = 12,
    parameter int GAIN_FRAC  = 8,
    parameter bit HP_PRESENT = 1'b1,
    parameter int HP_SHIFT   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       cmp_in,
    input  logic                    hp_en,
    input  logic [DEC_LOG2+1:0]     offset_cfg,
    input  logic [GAIN_W-1:0]       gain_cfg,
    output logic [NUM_CH-1:0]       fb_out,
    output logic                    smp_valid,
    output logic [NUM_CH*OUT_W-1:0] smp_data
);
    localparam int SUM_W = DEC_LOG2 + 1;
    localparam int YW    = SUM_W + 1;
    localparam int OFF_W = DEC_LOG2 + 2;

    logic win_end;
    logic word_vld;
    logic out_vld;

    sd_decim_ctl #(
        .DEC_LOG2 (DEC_LOG2)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .win_end  (win_end),
        .word_vld (word_vld),
        .out_vld  (out_vld)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic [SUM_W-1:0]     raw_word;
            logic signed [YW-1:0] filt;

            sd_boxcar #(
                .DEC_LOG2 (DEC_LOG2)
            ) u_box (
                .clk     (clk),
                .rst     (rst),
                .cmp_bit (cmp_in[c]),
                .win_end (win_end),
                .fb_bit  (fb_out[c]),
                .word    (raw_word)
            );

            sd_dcblock #(
                .DEC_LOG2   (DEC_LOG2),
                .HP_PRESENT (HP_PRESENT),
                .HP_SHIFT   (HP_SHIFT)
            ) u_dc (
                .clk   (clk),
                .rst   (rst),
                .hp_en (hp_en),
                .x     (raw_word),
                .x_vld (word_vld),
                .y     (filt)
            );

            sd_calib #(
                .YW        (YW),
                .OFF_W     (OFF_W),
                .GAIN_W    (GAIN_W),
                .GAIN_FRAC (GAIN_FRAC),
                .OUT_W     (OUT_W)
            ) u_cal (
                .clk    (clk),
                .rst    (rst),
                .y      (filt),
                .y_vld  (word_vld),
                .offset ($signed(offset_cfg)),
                .gain   (gain_cfg),
                .q      (smp_data[c*OUT_W +: OUT_W])
            );
        end
    endgenerate

    assign smp_valid = out_vld;

endmodule

// File: tb/sdadc_backend_test.sv
module sdadc_backend_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 3;
    localparam int DL2    = 3;
    localparam int R      = 1 << DL2;
    localparam int OUT_W  = 8;
    localparam int GAIN_W = 12;
    localparam int FRAC   = 8;
    localparam int HPS    = 2;
    localparam int OFF_W  = DL2 + 2;
    localparam int FULL   = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] cmp_in = '0;
    logic hp_en = 1'b0;
    logic [OFF_W-1:0] offset_cfg = '0;
    logic [GAIN_W-1:0] gain_cfg = GAIN_W'(256);
    logic [NCH-1:0] fb_out;
    logic smp_valid;
    logic [NCH*OUT_W-1:0] smp_data;

    sdadc_backend #(
        .NUM_CH(NCH), .DEC_LOG2(DL2), .OUT_W(OUT_W), .GAIN_W(GAIN_W),
        .GAIN_FRAC(FRAC), .HP_PRESENT(1'b1), .HP_SHIFT(HPS)
    ) uut (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .hp_en(hp_en),
        .offset_cfg(offset_cfg), .gain_cfg(gain_cfg),
        .fb_out(fb_out), .smp_valid(smp_valid), .smp_data(smp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string tag = "";
    logic [NCH*OUT_W-1:0] expq[$];
    logic [NCH-1:0] exp_fb = '0;
    int edge_idx = -1;
    bit mon_on = 0;
    int last_vld = 0;
    bit first_seen = 0;
    int n_smp = 0;
    bit loop_phase = 0;
    int pmode[NCH];
    int vin[NCH];
    int hp_acc[NCH];
    int win_sum[NCH];
    bit prev_fb[NCH];
    int integ[NCH];
    int off_i = 0;
    int gain_i = 256;
    bit hp_i = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cal_model(input int y);
        int p;
        p = ((y - off_i) * gain_i) >>> FRAC;
        if (p > (1 << (OUT_W-1)) - 1) p = (1 << (OUT_W-1)) - 1;
        if (p < -(1 << (OUT_W-1))) p = -(1 << (OUT_W-1));
        return p;
    endfunction

    function automatic bit pat_bit(input int mode, input int ch, input int k);
        case (mode)
            0: return 1'b0;
            1: return 1'b1;
            2: return 1'(k % 2);
            default: return ((k * k + 3 * k + ch) % 7) < 3;
        endcase
    endfunction

    function automatic bit next_cmp(input int ch, input int k);
        if (pmode[ch] == 4) begin
            integ[ch] = integ[ch] + vin[ch] - (prev_fb[ch] ? FULL : 0);
            return integ[ch] >= 0;
        end
        return pat_bit(pmode[ch], ch, k);
    endfunction

    // monitor: pops the scoreboard as words appear
    always @(negedge clk) begin
        if (mon_on) begin
            check(fb_out == exp_fb, "R1", "fb_out", int'(fb_out), int'(exp_fb));
            if (smp_valid) begin
                logic [NCH*OUT_W-1:0] e;
                if (!first_seen) begin
                    check(edge_idx == R, "R2", "first strobe edge", edge_idx, R);
                end else begin
                    check(edge_idx - last_vld == R, "R4", "strobe spacing", edge_idx - last_vld, R);
                end
                first_seen = 1;
                last_vld = edge_idx;
                if (expq.size() == 0) begin
                    check(1'b0, "R4", "unexpected strobe", 1, 0);
                end else begin
                    e = expq.pop_front();
                    for (int ch = 0; ch < NCH; ch++) begin
                        int a, x;
                        a = int'($signed(smp_data[ch*OUT_W +: OUT_W]));
                        x = int'($signed(e[ch*OUT_W +: OUT_W]));
                        check(a == x, tag, $sformatf("ch%0d word", ch), a, x);
                        if (loop_phase && n_smp >= 2) begin
                            int tgt;
                            tgt = (vin[ch] * R) / FULL;
                            check(a - tgt <= 2 && tgt - a <= 2, "R10", "density", a, tgt);
                        end
                    end
                end
                n_smp++;
            end
        end
    end

    task automatic run_phase(input string t, input int nwin);
        tag = t;
        rst = 1'b1;
        mon_on = 0;
        cmp_in = '0;
        repeat (3) @(posedge clk);
        #2;
        check(fb_out == '0, "R2", "fb_out in reset", int'(fb_out), 0);
        check(smp_valid == 1'b0, "R2", "strobe in reset", int'(smp_valid), 0);
        expq.delete();
        for (int ch = 0; ch < NCH; ch++) begin
            prev_fb[ch] = 0; win_sum[ch] = 0; hp_acc[ch] = 0; integ[ch] = 0;
        end
        first_seen = 0; n_smp = 0; edge_idx = -1; exp_fb = '0;
        rst = 1'b0;
        for (int ch = 0; ch < NCH; ch++) cmp_in[ch] = next_cmp(ch, 0);
        mon_on = 1;
        for (int k = 0; k < nwin * R + 2; k++) begin
            @(posedge clk);
            #2;
            for (int ch = 0; ch < NCH; ch++) begin
                win_sum[ch] += int'(prev_fb[ch]);
                prev_fb[ch] = cmp_in[ch];
            end
            exp_fb = cmp_in;
            edge_idx = k;
            if (k % R == R - 1) begin
                logic [NCH*OUT_W-1:0] e;
                for (int ch = 0; ch < NCH; ch++) begin
                    int x, y, tap, v;
                    x = win_sum[ch];
                    if (hp_i) begin
                        tap = hp_acc[ch] >>> HPS;
                        y = x - tap;
                        hp_acc[ch] = hp_acc[ch] + x - tap;
                    end else begin
                        y = x;
                    end
                    v = cal_model(y);
                    e[ch*OUT_W +: OUT_W] = OUT_W'(v);
                    win_sum[ch] = 0;
                end
                expq.push_back(e);
            end
            for (int ch = 0; ch < NCH; ch++) cmp_in[ch] = next_cmp(ch, k + 1);
        end
        mon_on = 0;
        check(expq.size() == 0, "R4", "words left unseen", expq.size(), 0);
    endtask

    task automatic set_cfg(input bit hp, input int off, input int gain);
        hp_i = hp; off_i = off; gain_i = gain;
        hp_en = hp;
        offset_cfg = OFF_W'(off);
        gain_cfg = GAIN_W'(gain);
    endtask

    initial begin
        // ch0 ones, ch1 zeros, ch2 mixed; unity calibration, no DC block
        set_cfg(0, 0, 256);
        pmode[0] = 1; pmode[1] = 0; pmode[2] = 3;
        run_phase("R3 R7 R9", 6);
        // offset and fractional gain with floor rounding
        set_cfg(0, 3, 384);
        pmode[0] = 3; pmode[1] = 2; pmode[2] = 1;
        run_phase("R5", 6);
        // large gain, positive offset: lower clip
        set_cfg(0, 15, 4095);
        pmode[0] = 1; pmode[1] = 0; pmode[2] = 3;
        run_phase("R6 low", 4);
        // large gain, negative offset: upper clip
        set_cfg(0, -16, 4095);
        pmode[0] = 1; pmode[1] = 0; pmode[2] = 2;
        run_phase("R6 high", 4);
        // DC blocking of a step, a mixed pattern and a square wave
        set_cfg(1, 0, 256);
        pmode[0] = 1; pmode[1] = 3; pmode[2] = 2;
        run_phase("R8", 10);
        // closed loop through a modelled integrator
        set_cfg(0, 0, 256);
        pmode[0] = 4; pmode[1] = 4; pmode[2] = 4;
        vin[0] = 64; vin[1] = 128; vin[2] = 224;
        loop_phase = 1;
        run_phase("R10", 12);
        loop_phase = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule